// File: doc/BRIEF.md
# Last-Outcome Branch Direction Predictor

This block is a small direct-mapped history table that guesses whether a conditional branch will be taken. The guess is based on what that branch did the last times it executed. The fetch stage presents a fetch address and reads back a taken/not-taken guess in the same cycle. The table has no tags, so two branches whose addresses share the same index bits share one entry.

Branches resolve late, when the memory stage finishes. The resolving stage then presents the branch address and its real direction on the update port. In that same cycle the block compares the real direction with what the entry predicts. If they differ, it raises a mispredict flag and reports how many younger instructions the pipeline must discard: three, the ones in fetch, decode and execute. None of those instructions has written back yet, so discarding them is safe. The new history is written to the entry at the next clock edge.

A parameter sets the history width per entry. A width of 1 makes each entry simply remember the last direction. A width of 2 makes each entry a saturating counter, so a single unusual outcome does not flip the guess.

Top module: `lastdir_predictor`

## Requirements
- R1: After reset every entry is weakly not-taken (value 0 with 1-bit history, binary 01 with 2-bit history), so every lookup predicts not-taken.
- R2: The entry is selected by address bits [5:2] with the default 16 entries. Bits [1:0] and all bits above bit 5 have no effect, so addresses that differ only there share an entry.
- R3: With 1-bit history, an entry predicts exactly the direction given by the last update written to it.
- R4: With 2-bit history, an entry counts up on taken and down on not-taken, holds at 3 and at 0, and predicts taken when its value is 2 or 3.
- R5: `upd_mispredict` is high in a cycle only when `upd_valid` is high and the direction the addressed entry predicts differs from `upd_taken`. It is judged on the entry's contents before that cycle's write.
- R6: `upd_squash` is 3 in a cycle where `upd_mispredict` is high, and 0 otherwise.
- R7: An update takes effect at the clock edge that ends its cycle. A lookup of the same entry in that cycle returns the old prediction, and a lookup in the next cycle returns the new one.
- R8: An update changes only the entry it addresses.
- R9: While `upd_valid` is low, no entry changes, whatever `upd_pc` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | PC_W (32) | Fetch address to predict |
| predict_taken | output | 1 | Guess for lookup_pc: 1 = taken |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | PC_W (32) | Address of the resolving branch |
| upd_taken | input | 1 | Real direction of the resolving branch |
| upd_mispredict | output | 1 | The stored guess for upd_pc was wrong |
| upd_squash | output | clog2(SQUASH_DEPTH+1) (2) | Number of younger instructions to discard |

## Verification
A fetch lookup and a late branch update can address the same entry in the same cycle. The bench provokes this by driving both ports with one address inside a single cycle. It then reads the guess twice: once before the clock edge, where it must still equal the old history, and once after, where it must show the new history. It repeats the check for both history widths. The mispredict flag sampled in that same cycle must be judged against the old contents as well.

// File: rtl/lastdir_predictor.sv
module lastdir_predictor #(
  parameter int PC_W         = 32,
  parameter int ENTRIES      = 16,
  parameter int HIST_BITS    = 2,
  parameter int SQUASH_DEPTH = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [PC_W-1:0]                       lookup_pc,
  output logic                                  predict_taken,
  input  logic                                  upd_valid,
  input  logic [PC_W-1:0]                       upd_pc,
  input  logic                                  upd_taken,
  output logic                                  upd_mispredict,
  output logic [$clog2(SQUASH_DEPTH+1)-1:0]     upd_squash
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SQ_W  = $clog2(SQUASH_DEPTH+1);
  localparam logic [HIST_BITS-1:0] CTR_MAX = {HIST_BITS{1'b1}};
  localparam logic [HIST_BITS-1:0] RST_VAL = HIST_BITS'(HIST_BITS == 1 ? 0 : 1);

  logic [HIST_BITS-1:0] tbl [ENTRIES];
  logic [HIST_BITS-1:0] upd_old, upd_new;
  logic [IDX_W-1:0]     lk_idx, upd_idx;

  assign lk_idx  = lookup_pc[IDX_W+1:2];
  assign upd_idx = upd_pc[IDX_W+1:2];
  assign upd_old = tbl[upd_idx];

  wire unused_pc_bits = &{1'b0, lookup_pc[PC_W-1:IDX_W+2], lookup_pc[1:0],
                          upd_pc[PC_W-1:IDX_W+2], upd_pc[1:0]};

  assign predict_taken  = tbl[lk_idx][HIST_BITS-1];
  assign upd_mispredict = upd_valid & (upd_old[HIST_BITS-1] ^ upd_taken);
  assign upd_squash     = upd_mispredict ? SQ_W'(SQUASH_DEPTH) : '0;

  generate
    if (HIST_BITS == 1) begin : g_last
      assign upd_new = upd_taken;
    end else begin : g_ctr
      always_comb begin
        upd_new = upd_old;
        if (upd_taken && upd_old != CTR_MAX)
          upd_new = upd_old + 1'b1;
        else if (!upd_taken && upd_old != '0)
          upd_new = upd_old - 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= RST_VAL;
    end else if (upd_valid) begin
      tbl[upd_idx] <= upd_new;
    end
  end

  p_quiet_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !upd_mispredict);

  p_squash_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_mispredict |-> upd_squash == SQ_W'(SQUASH_DEPTH));

  p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_old == CTR_MAX) |=> tbl[$past(upd_idx)] == CTR_MAX);

  p_sat_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_old == '0) |=> tbl[$past(upd_idx)] == '0);

  p_follow_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (HIST_BITS == 1 && upd_valid) |=> tbl[$past(upd_idx)][HIST_BITS-1] == $past(upd_taken));
endmodule

// File: tb/lastdir_predictor_tb.sv
module lastdir_predictor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] lookup_pc = 0, upd_pc = 0;
  logic        upd_valid = 0, upd_taken = 0;
  logic        p2, m2o, p1, m1o;
  logic [1:0]  s2, s1;

  int n_chk = 0, n_err = 0;
  int m2 [16];
  int m1 [16];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lastdir_predictor #(.HIST_BITS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .predict_taken(p2),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispredict(m2o), .upd_squash(s2));

  lastdir_predictor #(.HIST_BITS(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .predict_taken(p1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_mispredict(m1o), .upd_squash(s1));

  function automatic int ix(logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] pc, string req);
    @(negedge clk);
    lookup_pc = pc;
    #1;
    chk({req, " 2-bit guess"}, int'(p2), int'(m2[ix(pc)] >= 2));
    chk({req, " 1-bit guess"}, int'(p1), m1[ix(pc)]);
  endtask

  task automatic model_write(logic [31:0] pc, bit t);
    int i = ix(pc);
    m1[i] = t;
    if (t) m2[i] = (m2[i] == 3) ? 3 : m2[i] + 1;
    else   m2[i] = (m2[i] == 0) ? 0 : m2[i] - 1;
  endtask

  task automatic upd(logic [31:0] pc, bit t, string req);
    bit e2, e1;
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_taken = t;
    #1;
    e2 = (m2[ix(pc)] >= 2) != t;
    e1 = (m1[ix(pc)] != 0) != t;
    chk({req, " R5 mispredict 2-bit"}, int'(m2o), int'(e2));
    chk({req, " R5 mispredict 1-bit"}, int'(m1o), int'(e1));
    chk({req, " R6 squash 2-bit"}, int'(s2), e2 ? 3 : 0);
    chk({req, " R6 squash 1-bit"}, int'(s1), e1 ? 3 : 0);
    @(posedge clk);
    model_write(pc, t);
    #1 upd_valid = 0;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 16; i++) look(32'hABC0_0303 | (i << 2), req);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) begin m2[i] = 1; m1[i] = 0; end
    sweep("R1");
    chk("R1 no flag", int'(m2o | m1o), 0);
  endtask

  task automatic t_last_outcome;
    upd(32'h20, 1, "R3"); look(32'h20, "R3");
    upd(32'h20, 1, "R3"); look(32'h20, "R3");
    upd(32'h20, 0, "R3"); look(32'h20, "R3");
    upd(32'h20, 1, "R3"); look(32'h20, "R3");
  endtask

  task automatic t_counter;
    for (int k = 0; k < 4; k++) begin upd(32'h24, 1, "R4 up"); look(32'h24, "R4 up"); end
    for (int k = 0; k < 5; k++) begin upd(32'h24, 0, "R4 down"); look(32'h24, "R4 down"); end
    upd(32'h24, 1, "R4 floor"); look(32'h24, "R4 floor");
  endtask

  task automatic t_alias;
    upd(32'h44, 1, "R2"); upd(32'h8000_0045, 1, "R2");
    look(32'h04, "R2"); look(32'h06, "R2");
    sweep("R8");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lookup_pc = 32'h30; upd_valid = 1; upd_pc = 32'h30; upd_taken = 1;
    #1;
    chk("R7 old guess 2-bit", int'(p2), int'(m2[12] >= 2));
    chk("R7 old guess 1-bit", int'(p1), m1[12]);
    chk("R7 R5 flag 2-bit", int'(m2o), int'(m2[12] < 2));
    @(posedge clk);
    model_write(32'h30, 1);
    #1;
    upd_valid = 0;
    chk("R7 new guess 2-bit", int'(p2), int'(m2[12] >= 2));
    chk("R7 new guess 1-bit", int'(p1), m1[12]);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      upd_valid = 0; upd_pc = k << 2; upd_taken = k[0];
      #1;
      chk("R5 idle flag", int'(m2o | m1o), 0);
      chk("R6 idle squash", int'(s2 | s1), 0);
    end
    sweep("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_last_outcome();
    t_counter();
    t_alias();
    t_same_cycle();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule